// File: doc/BRIEF.md
# Video component depth normalizer

This block sits on a multi-pixel video stream and rewrites the width of every colour component. Each beat carries two or four pixels. Each pixel has three components, and every component arrives in a 16-bit field that holds the sample right-justified. A runtime code gives the real sample depth of the incoming video (8, 10, 12 or 16 bits). A build parameter fixes the component width on the output (8, 10, 12 or 16 bits). A component deeper than the output width loses its low bits. A shallower one is placed at the top of the output field, with zeros below it. A separate mode input selects 4:2:2 video, which always counts as 12 bits deep.

Both sides use a valid/ready handshake. A beat moves when valid and ready are both high at a rising clock edge. The block holds one register stage. It accepts a new beat whenever that stage is empty or is being drained in the same cycle. While the output is stalled, the output beat stays frozen and the input is refused. Start-of-frame (`s_tuser`) and end-of-line (`s_tlast`) travel with the data. The depth settings are captured only on an accepted start-of-frame beat, so one frame is never converted with two depths.

Top module: `vid_depth_norm`

## Requirements
- R1: Pixel p, component c (c = 0 for G/Y, 1 for B/U, 2 for R/V) is lane k = 3p + c. It is read from `s_tdata[16k +: 16]` and written to `m_tdata[OUT_BPC*k +: OUT_BPC]`.
- R2: `cfg_depth` encodes the incoming depth as 0 = 8 bits, 1 = 10, 2 = 12 and 3 = 16. Codes 4 to 7 are treated as 8 bits.
- R3: When the incoming depth A is greater than OUT_BPC, each output component equals input bits [A-1 : A-OUT_BPC].
- R4: When A is at most OUT_BPC, the top A bits of each output component equal input bits [A-1:0], and the lowest OUT_BPC-A bits are zero.
- R5: Input bits at or above position A in a 16-bit component field have no effect on the output.
- R6: When `cfg_yuv422` is 1, the incoming depth is taken as 12 bits, whatever `cfg_depth` holds.
- R7: `cfg_depth` and `cfg_yuv422` are sampled only on an accepted beat with `s_tuser` = 1. That beat and every later beat up to the next such beat use the sampled values. Before the first such beat after reset, the depth is 8 bits.
- R8: A beat accepted at one edge appears on `m_tvalid`/`m_tdata` after that edge, with its own `s_tuser` and `s_tlast`, one cycle later when the output is not stalled.
- R9: `s_tready` is high exactly when `m_tvalid` is low or `m_tready` is high. While `m_tvalid` is high and `m_tready` is low, the output beat does not change.
- R10: While `rst_n` is low, `m_tvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 3 | Incoming depth code |
| cfg_yuv422 | input | 1 | 4:2:2 mode, forces 12-bit depth |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high with valid |
| s_tdata | input | LANES*48 | Input components, 16 bits each |
| s_tuser | input | 1 | Start of frame |
| s_tlast | input | 1 | End of line |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | LANES*3*OUT_BPC | Output components |
| m_tuser | output | 1 | Start of frame, delayed |
| m_tlast | output | 1 | End of line, delayed |

## Verification
The hardest situation to reach from the ports is a depth change that arrives in the middle of a frame while the output is stalled. It must not affect the beats already in flight or the beats still to come in that frame. The bench drives a fresh random depth code and mode on every beat that is not a start-of-frame. It sends frames that walk through all eight codes and the 4:2:2 mode, and it drops valid and ready at random so that start-of-frame beats often wait through back-pressure. Expected components come from a shift-and-mask model in the bench that keeps its own record of the captured depth.

// File: rtl/vdn_pkg.sv
package vdn_pkg;
  localparam int unsigned IN_COMP_W = 16;
  localparam int unsigned COMPS_PER_PIXEL = 3;
  localparam int unsigned DEPTH_W = 5;

  typedef logic [DEPTH_W-1:0] depth_t;

  // Incoming depth code to bit count; undefined codes fall back to 8 (R2)
  function automatic depth_t code_to_bits(input logic [2:0] code, input logic yuv422);
    depth_t bits;
    if (yuv422) begin
      bits = depth_t'(12);
    end else begin
      case (code)
        3'd1:    bits = depth_t'(10);
        3'd2:    bits = depth_t'(12);
        3'd3:    bits = depth_t'(16);
        default: bits = depth_t'(8);
      endcase
    end
    return bits;
  endfunction
endpackage

// File: rtl/vdn_depth_track.sv
module vdn_depth_track
  import vdn_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_depth,
  input  logic       cfg_yuv422,
  input  logic       sof,
  input  logic       take_sof,
  output depth_t     act_bits
);
  depth_t new_bits;
  depth_t held_q;

  always_comb new_bits = code_to_bits(cfg_depth, cfg_yuv422);

  // R7: settings latch only on an accepted start-of-frame beat
  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= depth_t'(8);
    else if (take_sof) held_q <= new_bits;
  end

  // The start-of-frame beat itself already uses the new setting
  always_comb act_bits = sof ? new_bits : held_q;
endmodule

// File: rtl/vdn_comp_scale.sv
module vdn_comp_scale
  import vdn_pkg::*;
#(
  parameter int unsigned OUT_BPC = 12
) (
  input  logic [IN_COMP_W-1:0] comp_in,
  input  depth_t               act_bits,
  output logic [OUT_BPC-1:0]   comp_out
);
  localparam depth_t OUT_BITS = depth_t'(OUT_BPC);

  logic [IN_COMP_W-1:0] keep_mask;
  logic [IN_COMP_W-1:0] clean;
  logic [IN_COMP_W-1:0] moved;

  always_comb begin
    // R5: clear junk above the real depth (shift by 16 wraps to all ones)
    keep_mask = (IN_COMP_W'(1) << act_bits) - IN_COMP_W'(1);
    clean     = comp_in & keep_mask;
    if (act_bits > OUT_BITS) moved = clean >> (act_bits - OUT_BITS);  // R3
    else                     moved = clean << (OUT_BITS - act_bits);  // R4
    comp_out  = moved[OUT_BPC-1:0];
  end

  // R4: a shallower sample leaves its zero fill in the low bits
  always_comb begin
    if (!$isunknown({act_bits, comp_out}) && act_bits < OUT_BITS) begin
      a_r4_zero_fill: assert ((comp_out & ((OUT_BPC'(1) << (OUT_BITS - act_bits)) - OUT_BPC'(1))) == '0)
        else $error("low fill bits not zero");
    end
  end
endmodule

// File: rtl/vdn_pipe_reg.sv
module vdn_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (in_ready) begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) dat_q <= in_data;
  end

  // R9: a stalled beat stays put
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data))
    else $error("stalled output changed");

  // R9: a stalled output refuses new input
  a_r9_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready)
    else $error("input accepted while output stalled");
endmodule

// File: rtl/vid_depth_norm.sv
module vid_depth_norm
  import vdn_pkg::*;
#(
  parameter int unsigned LANES   = 2,
  parameter int unsigned OUT_BPC = 12
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [2:0]                             cfg_depth,
  input  logic                                   cfg_yuv422,
  input  logic                                   s_tvalid,
  output logic                                   s_tready,
  input  logic [LANES*COMPS_PER_PIXEL*16-1:0]    s_tdata,
  input  logic                                   s_tuser,
  input  logic                                   s_tlast,
  output logic                                   m_tvalid,
  input  logic                                   m_tready,
  output logic [LANES*COMPS_PER_PIXEL*OUT_BPC-1:0] m_tdata,
  output logic                                   m_tuser,
  output logic                                   m_tlast
);
  localparam int unsigned NCOMP  = LANES * COMPS_PER_PIXEL;
  localparam int unsigned OUT_W  = NCOMP * OUT_BPC;
  localparam int unsigned PAY_W  = OUT_W + 2;

  depth_t           act_bits;
  logic [OUT_W-1:0] scaled;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  vdn_depth_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_depth  (cfg_depth),
    .cfg_yuv422 (cfg_yuv422),
    .sof        (s_tuser),
    .take_sof   (s_tvalid && s_tready && s_tuser),
    .act_bits   (act_bits)
  );

  // R1: one scaler per component lane, same order on both sides
  for (genvar k = 0; k < NCOMP; k++) begin : g_lane
    vdn_comp_scale #(.OUT_BPC(OUT_BPC)) u_scale (
      .comp_in  (s_tdata[k*IN_COMP_W +: IN_COMP_W]),
      .act_bits (act_bits),
      .comp_out (scaled[k*OUT_BPC +: OUT_BPC])
    );
  end

  assign pay_in = {s_tlast, s_tuser, scaled};

  vdn_pipe_reg #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_tvalid),
    .in_ready  (s_tready),
    .in_data   (pay_in),
    .out_valid (m_tvalid),
    .out_ready (m_tready),
    .out_data  (pay_out)
  );

  assign m_tdata = pay_out[OUT_W-1:0];
  assign m_tuser = pay_out[OUT_W];
  assign m_tlast = pay_out[OUT_W+1];

  // R8: an accepted beat lands on the output with its own sideband
  a_r8_accept_lands: assert property (@(posedge clk) disable iff (!rst_n)
    s_tvalid && s_tready |=> m_tvalid && m_tuser == $past(s_tuser) && m_tlast == $past(s_tlast))
    else $error("accepted beat missing or sideband wrong");
endmodule

// File: tb/tb_vid_depth_norm.sv
module tb_vid_depth_norm;
  localparam int LANES = 2;
  localparam int OUT_BPC = 12;
  localparam int NC = LANES * 3;
  localparam int IW = NC * 16;
  localparam int OW = NC * OUT_BPC;
  localparam int PRE = 2;
  localparam int NFR = 12;
  localparam int BPF = 8;
  localparam int NB = PRE + NFR * BPF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_depth = '0;
  logic cfg_yuv422 = 1'b0;
  logic s_tvalid = 1'b0;
  logic s_tready;
  logic [IW-1:0] s_tdata = '0;
  logic s_tuser = 1'b0;
  logic s_tlast = 1'b0;
  logic m_tvalid;
  logic m_tready = 1'b0;
  logic [OW-1:0] m_tdata;
  logic m_tuser;
  logic m_tlast;

  always #5 clk = ~clk;

  vid_depth_norm #(.LANES(LANES), .OUT_BPC(OUT_BPC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_yuv422(cfg_yuv422),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tuser(s_tuser), .s_tlast(s_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tuser(m_tuser), .m_tlast(m_tlast));

  int checks = 0;
  int errors = 0;

  logic [OW+1:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  function automatic int dec(input int code, input bit yuv);
    if (yuv) return 12;
    case (code)
      1: return 10;
      2: return 12;
      3: return 16;
      default: return 8;
    endcase
  endfunction

  // Shift-and-mask reference, lane k at 16k in and OUT_BPC*k out
  function automatic logic [OW-1:0] model(input logic [IW-1:0] din, input int a);
    logic [OW-1:0] r;
    r = '0;
    for (int k = 0; k < NC; k++) begin
      int v;
      int e;
      v = int'(din[16*k +: 16]) & ((1 << a) - 1);
      e = (a > OUT_BPC) ? (v >> (a - OUT_BPC)) : (v << (OUT_BPC - a));
      r[k*OUT_BPC +: OUT_BPC] = e[OUT_BPC-1:0];
    end
    return r;
  endfunction

  function automatic int sof_code(input int f);
    int tbl[4] = '{3, 0, 5, 1};
    if (f < 8) return f;
    return tbl[f-8];
  endfunction

  initial begin
    int b = 0;
    int held_a = 8;
    int cycles = 0;
    bit acc = 0;
    bit stalled = 0;
    bit pre_frame = 1;
    bit timeout = 0;
    logic [OW-1:0] stall_data = '0;

    repeat (3) @(negedge clk);
    chk(m_tvalid == 1'b0, "R10 reset valid", 128'(m_tvalid), 128'(0));
    rst_n = 1'b1;

    while ((b < NB || exp_q.size() > 0) && !timeout) begin
      @(negedge clk);
      if (!s_tvalid || acc) begin
        if (b < NB && ($urandom % 10) < 7) begin
          s_tvalid = 1'b1;
          for (int k = 0; k < NC; k++) s_tdata[16*k +: 16] = 16'($urandom);
          if (b < PRE) begin
            s_tuser = 1'b0;
            s_tlast = 1'b0;
            cfg_depth = 3'($urandom);
            cfg_yuv422 = 1'($urandom);
          end else begin
            int fb = b - PRE;
            int f = fb / BPF;
            int i = fb % BPF;
            s_tuser = (i == 0);
            s_tlast = ((i % 4) == 3);
            if (i == 0) begin
              cfg_depth = 3'(sof_code(f));
              cfg_yuv422 = (f >= 8);
            end else begin
              // R7: mid-frame setting changes must be ignored
              cfg_depth = 3'($urandom);
              cfg_yuv422 = 1'($urandom);
            end
          end
          b++;
        end else begin
          s_tvalid = 1'b0;
        end
      end
      m_tready = (($urandom % 4) != 0);
      #1;
      chk(s_tready == (!m_tvalid || m_tready), "R9 ready rule", 128'(s_tready), 128'(!m_tvalid || m_tready));
      if (stalled)
        chk(m_tvalid && m_tdata == stall_data, "R9 stalled beat held", 128'(m_tdata), 128'(stall_data));
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected output beat", 128'(m_tdata), 128'(0));
        end else begin
          logic [OW+1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(m_tdata == e[OW-1:0], {t, " data R1 R5 R7"}, 128'(m_tdata), 128'(e[OW-1:0]));
          chk({m_tlast, m_tuser} == e[OW+1:OW], "R8 sideband", 128'({m_tlast, m_tuser}), 128'(e[OW+1:OW]));
        end
      end
      stalled = m_tvalid && !m_tready;
      stall_data = m_tdata;
      acc = s_tvalid && s_tready;
      if (acc) begin
        string t;
        if (s_tuser) begin
          held_a = dec(int'(cfg_depth), cfg_yuv422);
          pre_frame = 0;
        end
        if (pre_frame) t = "R7 pre-frame";
        else if (held_a == 12 && (dec(int'(cfg_depth), 1'b0) != 12 || !s_tuser) && cfg_yuv422 && s_tuser) t = "R6";
        else if (s_tuser && cfg_depth > 3'd3) t = "R2";
        else if (held_a > OUT_BPC) t = "R3";
        else t = "R4";
        exp_q.push_back({s_tlast, s_tuser, model(s_tdata, held_a)});
        tag_q.push_back(t);
      end
      cycles++;
      if (cycles > 20000) begin
        timeout = 1;
        chk(1'b0, "R8 watchdog expired", 128'(cycles), 128'(0));
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule